// File: doc/BRIEF.md
# Bunch Group Pattern Generator

The block keeps, for every bunch crossing of one machine turn, a small word of gate flags, one bit per bunch group. A crossing counter steps once per clock, one clock being one 25 ns crossing, and walks through this table. Each clock the word for the current crossing comes out as a set of registered gate lines. Downstream logic can use these lines as internal triggers, or AND them with other signals as per-crossing gates.

The counter follows the orbit signal. A rising edge on the orbit input reloads the counter with a programmable crossing offset, which places the start of the pattern at the chosen distance from the orbit marker. Without orbit edges the counter runs freely and wraps once per turn. Software changes pattern bits through a masked write port. A write touches only the selected groups of one crossing word. It shows on the gates the next time the counter reaches that crossing.

Top module: `bgp_gen`

## Requirements
- R1: While `rst` is high, `gate_o` is all zero and the crossing counter is held at 0. After the first clock edge with `rst` low, `gate_o` shows the word of crossing 0. After the k-th such edge (counting from 0, with no orbit edge), it shows the word of crossing k mod 3564.
- R2: Without orbit edges the counter advances by one per clock and wraps from crossing 3563 to crossing 0, so the gate pattern repeats every 3564 clocks.
- R3: An orbit rising edge is a clock edge at which `orbit_i` is 1 and was 0 at the previous edge. That edge loads `cfg_offset_i` into the counter. At that same edge `gate_o` still takes the word of the crossing the counter held before the load. At the following edge `gate_o` shows the word of crossing `cfg_offset_i`, and the pattern then continues from there, wrapping at 3563.
- R4: If `orbit_i` stays high for several clocks, the counter is reloaded only once, at the rising edge, and it keeps counting while the level stays high.
- R5: An offset of 3564 or more loaded at an orbit edge puts the counter at crossing 0.
- R6: A write with `wr_en_i` high and `wr_addr_i` below 3564 sets bit g of that crossing's word to `wr_data_i[g]`, but only where `wr_mask_i[g]` is 1. Bits whose mask bit is 0 keep their value. Writes to addresses of 3564 or more have no effect.
- R7: If a write hits the crossing that the counter is reading in the same clock, `gate_o` shows the old word at that edge. The new word appears on the next visit to that crossing.
- R8: Bit g of `gate_o` is bit g of the crossing word, and each group follows its own pattern independently of the other groups.
- R9: Writes are accepted while `rst` is high, and their values appear after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock, one edge per bunch crossing |
| rst | input | 1 | Synchronous active-high reset |
| orbit_i | input | 1 | Orbit marker; its rising edge realigns the counter |
| cfg_offset_i | input | 12 | Crossing number loaded at an orbit edge |
| wr_en_i | input | 1 | Pattern write strobe |
| wr_addr_i | input | 12 | Crossing whose word is written |
| wr_mask_i | input | 4 | Per-group write enable |
| wr_data_i | input | 4 | Per-group new flag values |
| gate_o | output | 4 | Registered bunch group gates, one bit per group |

## Verification
The bench concentrates on the turn boundary, the orbit timing and the write port. For the turn boundary it drives offsets of 3563 and 3560 so that the pattern crosses from the last crossing to crossing 0. A counter that wrapped one step late, or failed to wrap, would show crossing 3564 garbage or shift the whole pattern. For the orbit it holds the level high for several clocks and loads an out-of-range offset. A level-sensitive reload would freeze the gates on the offset word, and an unclamped offset would read past the table. For the write port it writes with a partial mask and into the crossing being read. A design that ignored the mask would corrupt the other groups, and one with write-through forwarding would show the new word one turn early. Reset is pulsed mid-run with a write landing during it, to catch gates that stay stale or a table write that is blocked by reset.

// File: rtl/bgp_pkg.sv
package bgp_pkg;

    localparam int unsigned BGP_TURN_LEN   = 3564;
    localparam int unsigned BGP_NUM_GROUPS = 4;

    typedef enum logic [1:0] {
        BC_CLEAR = 2'd0,
        BC_STEP  = 2'd1,
        BC_WRAP  = 2'd2,
        BC_LOAD  = 2'd3
    } bc_op_e;

    // Priority: reset, then orbit reload, then turn wrap, then plain step.
    function automatic bc_op_e bc_decide(input logic clr, input logic load,
                                         input logic at_last);
        bc_op_e op;
        if (clr)
            op = BC_CLEAR;
        else if (load)
            op = BC_LOAD;
        else if (at_last)
            op = BC_WRAP;
        else
            op = BC_STEP;
        return op;
    endfunction

endpackage

// File: rtl/bgp_orbit_edge.sv
module bgp_orbit_edge (
    input  logic clk,
    input  logic rst,
    input  logic orbit_i,
    output logic load_o
);
    logic orbit_q;

    always_ff @(posedge clk) begin
        if (rst)
            orbit_q <= 1'b0;
        else
            orbit_q <= orbit_i;
    end

    assign load_o = orbit_i & ~orbit_q;

    // A held-high orbit yields one reload only.
    p_single_load_r4: assert property (@(posedge clk) disable iff (rst)
        load_o |=> !load_o);

endmodule

// File: rtl/bgp_bc_counter.sv
module bgp_bc_counter #(
    parameter int unsigned TURN_LEN = bgp_pkg::BGP_TURN_LEN,
    localparam int unsigned CNT_W   = $clog2(TURN_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] offset_i,
    output logic [CNT_W-1:0] cnt_o
);
    import bgp_pkg::*;

    localparam logic [CNT_W-1:0] LAST = CNT_W'(TURN_LEN - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;
    bc_op_e           op;

    always_comb begin
        load_val = (offset_i <= LAST) ? offset_i : '0;
        op       = bc_decide(rst, load_i, cnt_q == LAST);
    end

    always_ff @(posedge clk) begin
        unique case (op)
            BC_CLEAR: cnt_q <= '0;
            BC_LOAD:  cnt_q <= load_val;
            BC_WRAP:  cnt_q <= '0;
            default:  cnt_q <= cnt_q + 1'b1;
        endcase
    end

    assign cnt_o = cnt_q;

    p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    p_turn_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (!load_i && cnt_q == LAST) |=> cnt_q == '0);

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (!load_i && cnt_q != LAST) |=> cnt_q == $past(cnt_q) + 1'b1);

    p_orbit_load_r3: assert property (@(posedge clk) disable iff (rst)
        (load_i && offset_i <= LAST) |=> cnt_q == $past(offset_i));

    p_bad_offset_r5: assert property (@(posedge clk) disable iff (rst)
        (load_i && offset_i > LAST) |=> cnt_q == '0);

endmodule

// File: rtl/bgp_pattern_mem.sv
module bgp_pattern_mem #(
    parameter int unsigned TURN_LEN = bgp_pkg::BGP_TURN_LEN,
    parameter int unsigned GROUPS   = bgp_pkg::BGP_NUM_GROUPS,
    localparam int unsigned CNT_W   = $clog2(TURN_LEN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [CNT_W-1:0]  wr_addr_i,
    input  logic [GROUPS-1:0] wr_mask_i,
    input  logic [GROUPS-1:0] wr_data_i,
    input  logic [CNT_W-1:0]  rd_addr_i,
    output logic [GROUPS-1:0] rd_q_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TURN_LEN - 1);

    logic [GROUPS-1:0] table_q [TURN_LEN];
    logic [GROUPS-1:0] rd_q;
    logic              wr_ok;

    assign wr_ok = wr_en_i && (wr_addr_i <= LAST);

    // Table is not reset; writes are honoured during reset too.
    for (genvar g = 0; g < GROUPS; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (wr_ok && wr_mask_i[g])
                table_q[wr_addr_i][g] <= wr_data_i[g];
        end
    end

    // Read-before-write: a colliding write is seen on the next visit.
    always_ff @(posedge clk) begin
        if (rst)
            rd_q <= '0;
        else
            rd_q <= table_q[rd_addr_i];
    end

    assign rd_q_o = rd_q;

    // Checker bookkeeping for the mask property.
    logic              chk_wr_q;
    logic [CNT_W-1:0]  chk_addr_q;
    logic [GROUPS-1:0] chk_mask_q;
    logic [GROUPS-1:0] chk_pre_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_wr_q   <= 1'b0;
            chk_addr_q <= '0;
            chk_mask_q <= '0;
            chk_pre_q  <= '0;
        end else begin
            chk_wr_q   <= wr_ok;
            chk_addr_q <= wr_addr_i;
            chk_mask_q <= wr_mask_i;
            chk_pre_q  <= wr_ok ? table_q[wr_addr_i] : '0;
        end
    end

    p_mask_keep_r6: assert property (@(posedge clk) disable iff (rst)
        chk_wr_q |-> ((table_q[chk_addr_q] ^ chk_pre_q) & ~chk_mask_q) == '0);

    p_gate_reset_r1: assert property (@(posedge clk)
        rst |=> rd_q == '0);

endmodule

// File: rtl/bgp_gen.sv
module bgp_gen #(
    parameter int unsigned TURN_LEN = bgp_pkg::BGP_TURN_LEN,
    parameter int unsigned GROUPS   = bgp_pkg::BGP_NUM_GROUPS,
    localparam int unsigned CNT_W   = $clog2(TURN_LEN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              orbit_i,
    input  logic [CNT_W-1:0]  cfg_offset_i,
    input  logic              wr_en_i,
    input  logic [CNT_W-1:0]  wr_addr_i,
    input  logic [GROUPS-1:0] wr_mask_i,
    input  logic [GROUPS-1:0] wr_data_i,
    output logic [GROUPS-1:0] gate_o
);
    logic             load;
    logic [CNT_W-1:0] bc_cnt;

    bgp_orbit_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .orbit_i (orbit_i),
        .load_o  (load)
    );

    bgp_bc_counter #(.TURN_LEN(TURN_LEN)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load_i   (load),
        .offset_i (cfg_offset_i),
        .cnt_o    (bc_cnt)
    );

    bgp_pattern_mem #(.TURN_LEN(TURN_LEN), .GROUPS(GROUPS)) u_mem (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_mask_i (wr_mask_i),
        .wr_data_i (wr_data_i),
        .rd_addr_i (bc_cnt),
        .rd_q_o    (gate_o)
    );

    // After reset release the counter starts at crossing 0 and steps.
    p_start_zero_r1: assert property (@(posedge clk)
        (rst && !orbit_i) |=> bc_cnt == '0);

endmodule

// File: tb/sim_bgp_gen.sv
module sim_bgp_gen;
    localparam int N  = 3564;
    localparam int G  = 4;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          orbit = 1'b0;
    logic [AW-1:0] offset = '0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [G-1:0]  wr_mask = '0;
    logic [G-1:0]  wr_data = '0;
    logic [G-1:0]  gate;

    always #2.5 clk = ~clk;

    bgp_gen u0 (
        .clk(clk), .rst(rst), .orbit_i(orbit), .cfg_offset_i(offset),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_mask_i(wr_mask),
        .wr_data_i(wr_data), .gate_o(gate)
    );

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // Reference model state, derived from the requirements.
    logic [G-1:0] ref_tab [N];
    int           mcnt = 0;
    logic         orb_prev = 1'b0;

    function automatic logic [G-1:0] pat(input int a);
        return G'(a ^ (a >> 4) ^ (a >> 8) ^ (a >> 2));
    endfunction

    task automatic step(input string tag, input bit chk);
        logic [G-1:0] exp;
        @(posedge clk);
        if (rst) begin
            exp = '0;
            mcnt = 0;
        end else begin
            exp = ref_tab[mcnt];
        end
        if (wr_en && int'(wr_addr) < N)
            for (int g = 0; g < G; g++)
                if (wr_mask[g]) ref_tab[int'(wr_addr)][g] = wr_data[g];
        if (!rst) begin
            if (orbit && !orb_prev)
                mcnt = (int'(offset) < N) ? int'(offset) : 0;
            else
                mcnt = (mcnt == N - 1) ? 0 : mcnt + 1;
            orb_prev = orbit;
        end else begin
            orb_prev = 1'b0;
        end
        @(negedge clk);
        if (chk) begin
            tests++;
            if (gate !== exp) begin
                fails++;
                $display("FAIL %s: gate=%b expected=%b", tag, gate, exp);
            end
        end
    endtask

    typedef struct packed {
        logic [11:0] off;
        logic        orb;
        logic [3:0]  hold;
        logic [12:0] run;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{off: 12'd0,    orb: 1'b0, hold: 4'd0, run: 13'd3600},
        '{off: 12'd0,    orb: 1'b1, hold: 4'd1, run: 13'd100},
        '{off: 12'd100,  orb: 1'b1, hold: 4'd1, run: 13'd50},
        '{off: 12'd3563, orb: 1'b1, hold: 4'd1, run: 13'd10},
        '{off: 12'd5,    orb: 1'b1, hold: 4'd6, run: 13'd20},
        '{off: 12'd4000, orb: 1'b1, hold: 4'd1, run: 13'd20},
        '{off: 12'd3560, orb: 1'b1, hold: 4'd1, run: 13'd3570},
        '{off: 12'd2000, orb: 1'b1, hold: 4'd2, run: 13'd30}
    };

    initial begin
        @(negedge clk);
        // R9: fill the table while reset is held; R1: gates stay zero.
        wr_en = 1'b1;
        wr_mask = '1;
        for (int a = 0; a < N; a++) begin
            wr_addr = AW'(a);
            wr_data = pat(a);
            step("R9", (a % 500) == 0);
        end
        wr_en = 1'b0;
        rst = 1'b0;
        for (int k = 0; k < 8; k++) step("R1", 1'b1);

        // Table-driven walk over orbit timing and offsets.
        foreach (VECS[i]) begin
            string tag;
            tag = (int'(VECS[i].off) >= N) ? "R5" :
                  (VECS[i].hold > 1)       ? "R4" :
                  VECS[i].orb              ? "R3" : "R2";
            offset = VECS[i].off;
            for (int h = 0; h < int'(VECS[i].hold); h++) begin
                orbit = VECS[i].orb;
                step(tag, 1'b1);
            end
            orbit = 1'b0;
            for (int r = 0; r < int'(VECS[i].run); r++) step(tag, 1'b1);
        end

        // R6: partial-mask write, then pass over that crossing.
        wr_en = 1'b1; wr_addr = 12'd500; wr_mask = 4'b0101; wr_data = ~pat(500);
        step("R6", 1'b1);
        wr_addr = 12'd4000; wr_mask = '1; wr_data = 4'b1111;
        step("R6", 1'b1);
        wr_en = 1'b0;
        offset = 12'd490; orbit = 1'b1; step("R6", 1'b1);
        orbit = 1'b0;
        for (int r = 0; r < 20; r++) step("R6", 1'b1);

        // R8: single-group words at neighbouring crossings.
        wr_en = 1'b1; wr_mask = '1;
        wr_addr = 12'd700; wr_data = 4'b1000; step("R8", 1'b1);
        wr_addr = 12'd701; wr_data = 4'b0001; step("R8", 1'b1);
        wr_addr = 12'd702; wr_data = 4'b0110; step("R8", 1'b1);
        wr_en = 1'b0;
        offset = 12'd698; orbit = 1'b1; step("R8", 1'b1);
        orbit = 1'b0;
        for (int r = 0; r < 8; r++) step("R8", 1'b1);

        // R7: write the crossing being read in the same clock.
        wr_en = 1'b1; wr_mask = '1;
        wr_addr = AW'(mcnt); wr_data = ~ref_tab[mcnt];
        step("R7", 1'b1);
        wr_en = 1'b0;
        for (int r = 0; r < N + 4; r++) step("R7", 1'b1);

        // R1 / R9: reset pulse mid-run with a write to crossing 0.
        rst = 1'b1;
        wr_en = 1'b1; wr_addr = 12'd0; wr_mask = '1; wr_data = ~ref_tab[0];
        step("R9", 1'b1);
        wr_en = 1'b0;
        step("R1", 1'b1);
        step("R1", 1'b1);
        rst = 1'b0;
        for (int r = 0; r < 10; r++) step("R1", 1'b1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule